// File: doc/BRIEF.md
# Smartcard Contact Activation Sequencer

This block decides when each contact of a smartcard is powered and when it is released. A power-up request is a low-to-high edge of the power request input while chip select is low. It turns on the card supply converter. The block then holds every card line off until the supply reports that it is in range. After that it switches the contacts on one at a time, a fixed number of clock cycles apart. The order is the supply contact, I/O, clock, the two auxiliary lines, and last the card reset.

A session ends in one of four ways: the request falls while chip select is low, the card is pulled out, the supply overcurrent detector fires, or the battery monitor reports undervoltage. The block then releases only the contacts that are on, in the exact reverse order and with the same spacing. Once the last contact is released it stops the converter. An abort may land at any point of the power-up ramp. The bidirectional lines go to high impedance while the chip is selected, and the card supply is actively discharged whenever the converter is off. A status bit reports that the card is fully powered.

Top module: `card_contact_seq`

## Requirements
- R1: After reset, and whenever the block is idle, all five contact enables are 0, the converter enable is 0 and the ready bit is 0.
- R2: A rising edge of `pwrReq` with `csN` low, `batLow` low, `cardOut` low and `overCur` low sets `convEn` at the next clock edge. A rising edge that arrives with `csN` high, `batLow` high or `cardOut` high is ignored.
- R3: No contact is enabled before `supplyGood` has been seen while waiting for the supply. The first contact turns on STEP_GAP edges after the edge at which `supplyGood` is taken.
- R4: Contacts turn on one per STEP_GAP edges in the order vccEn, ioEn, clkEn, auxEn, rstEn. The enables always form a thermometer in that order. `ready` rises one edge after rstEn and is high only while rstEn is high.
- R5: A deactivation starts on a falling edge of `pwrReq` with `csN` low, or on `cardOut`, `overCur` or `batLow` high. A falling edge of `pwrReq` while `csN` is high is ignored.
- R6: After a deactivation trigger, the contacts that are on are released in reverse order (rstEn, auxEn, clkEn, ioEn, vccEn), one per STEP_GAP edges, with the first release STEP_GAP edges after the trigger. `convEn` drops one edge after the last release, or one edge after the trigger if no contact was on.
- R7: A trigger taken in the same cycle as a pending ramp-up step wins: no further contact turns on after it.
- R8: Once a session has ended, a new one needs a fresh rising edge of `pwrReq` while idle. A request held high through the shutdown does not restart the block.
- R9: `convEn` is 0 in every cycle in which `batLow` is 1.
- R10: `supplyDischarge` is the inverse of `convEn` in every cycle.
- R11: `ioHiZ` and `auxHiZ` are 1 while `csN` is low or while their contact is not enabled. They are 0 only when `csN` is high and the contact is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| pwrReq | input | 1 | Session power request from the host |
| supplyGood | input | 1 | Card supply is inside its operating range |
| batLow | input | 1 | Battery undervoltage detected |
| cardOut | input | 1 | Card extraction detected |
| overCur | input | 1 | Card supply overcurrent fault |
| convEn | output | 1 | Card supply converter enable |
| supplyDischarge | output | 1 | Pull the card supply low |
| vccEn | output | 1 | Supply contact enable |
| ioEn | output | 1 | I/O contact enable |
| clkEn | output | 1 | Clock contact enable |
| auxEn | output | 1 | C4/C8 auxiliary contacts enable |
| rstEn | output | 1 | Card reset contact enable |
| ioHiZ | output | 1 | Put the I/O line in high impedance |
| auxHiZ | output | 1 | Put the auxiliary lines in high impedance |
| ready | output | 1 | All contacts are powered and the session is active |

## Verification
Some properties are checked by assertions on every cycle. The enables must stay a thermometer in the fixed order and may change by at most one contact per cycle. The battery flag must keep the converter off, and no contact may be on without a running converter. An extraction or overcurrent must never be followed by an extra contact turning on. The high-impedance and discharge outputs must follow chip select and the converter. Other behaviour can only be shown by the bench's scenarios. These cover the exact step spacing after the supply handshake and the full reverse teardown from every abort point under each trigger kind. They also cover the rejection of requests that are edge-qualified wrongly or arrive during shutdown.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;
  localparam int NUM_CONTACTS = 5;
  localparam int LVL_W = $clog2(NUM_CONTACTS + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_SUP,
    ST_RAMP_UP,
    ST_ACTIVE,
    ST_RAMP_DOWN
  } seqState_t;

  typedef struct packed {
    logic clrCnt;
    logic stepUp;
    logic stepDown;
  } seqStrobe_t;
endpackage

// File: rtl/card_seq_dp.sv
module card_seq_dp
  import card_seq_pkg::*;
#(
  parameter int STEP_GAP = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  seqStrobe_t              strb,
  output logic                    gapDone,
  output logic                    levelZero,
  output logic                    levelFull,
  output logic [NUM_CONTACTS-1:0] contactEn
);
  localparam int CNT_W = (STEP_GAP > 1) ? $clog2(STEP_GAP) : 1;
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(STEP_GAP - 1);
  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(NUM_CONTACTS);

  logic [CNT_W-1:0] gapCnt;
  logic [LVL_W-1:0] level;

  assign gapDone   = (gapCnt == GAP_LAST);
  assign levelZero = (level == '0);
  assign levelFull = (level == LVL_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gapCnt <= '0;
    end else if (strb.clrCnt || gapDone) begin
      gapCnt <= '0;
    end else begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= '0;
    end else if (strb.stepUp && !levelFull) begin
      level <= level + 1'b1;
    end else if (strb.stepDown && !levelZero) begin
      level <= level - 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_CONTACTS; i++) begin : g_decode
    assign contactEn[i] = (level > LVL_W'(i));
  end
endmodule

// File: rtl/card_seq_ctrl.sv
module card_seq_ctrl
  import card_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       csN,
  input  logic       pwrReq,
  input  logic       supplyGood,
  input  logic       batLow,
  input  logic       cardOut,
  input  logic       overCur,
  input  logic       gapDone,
  input  logic       levelZero,
  input  logic       levelFull,
  output seqStrobe_t strb,
  output logic       convOn,
  output logic       sessionReady
);
  seqState_t state, stateNext;
  logic reqPrev;
  logic reqRise, reqFall, endReq, startOk;

  assign reqRise = pwrReq & ~reqPrev;
  assign reqFall = ~pwrReq & reqPrev;
  assign endReq  = (reqFall & ~csN) | cardOut | overCur | batLow;
  assign startOk = reqRise & ~csN & ~batLow & ~cardOut & ~overCur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reqPrev <= 1'b0;
      state   <= ST_IDLE;
    end else begin
      reqPrev <= pwrReq;
      state   <= stateNext;
    end
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (startOk) stateNext = ST_WAIT_SUP;
      end
      ST_WAIT_SUP: begin
        if (endReq) begin
          stateNext   = ST_RAMP_DOWN;
          strb.clrCnt = 1'b1;
        end else if (supplyGood) begin
          stateNext   = ST_RAMP_UP;
          strb.clrCnt = 1'b1;
        end
      end
      ST_RAMP_UP: begin
        if (endReq) begin
          stateNext   = ST_RAMP_DOWN;
          strb.clrCnt = 1'b1;
        end else if (levelFull) begin
          stateNext = ST_ACTIVE;
        end else if (gapDone) begin
          strb.stepUp = 1'b1;
        end
      end
      ST_ACTIVE: begin
        if (endReq) begin
          stateNext   = ST_RAMP_DOWN;
          strb.clrCnt = 1'b1;
        end
      end
      ST_RAMP_DOWN: begin
        if (levelZero) begin
          stateNext = ST_IDLE;
        end else if (gapDone) begin
          strb.stepDown = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign convOn       = (state != ST_IDLE);
  assign sessionReady = (state == ST_ACTIVE);
endmodule

// File: rtl/card_contact_seq.sv
module card_contact_seq
  import card_seq_pkg::*;
#(
  parameter int STEP_GAP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csN,
  input  logic pwrReq,
  input  logic supplyGood,
  input  logic batLow,
  input  logic cardOut,
  input  logic overCur,
  output logic convEn,
  output logic supplyDischarge,
  output logic vccEn,
  output logic ioEn,
  output logic clkEn,
  output logic auxEn,
  output logic rstEn,
  output logic ioHiZ,
  output logic auxHiZ,
  output logic ready
);
  seqStrobe_t strb;
  logic gapDone, levelZero, levelFull, convOn;
  logic [NUM_CONTACTS-1:0] contactEn;

  card_seq_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .csN          (csN),
    .pwrReq       (pwrReq),
    .supplyGood   (supplyGood),
    .batLow       (batLow),
    .cardOut      (cardOut),
    .overCur      (overCur),
    .gapDone      (gapDone),
    .levelZero    (levelZero),
    .levelFull    (levelFull),
    .strb         (strb),
    .convOn       (convOn),
    .sessionReady (ready)
  );

  card_seq_dp #(.STEP_GAP(STEP_GAP)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .gapDone   (gapDone),
    .levelZero (levelZero),
    .levelFull (levelFull),
    .contactEn (contactEn)
  );

  assign convEn          = convOn & ~batLow;
  assign supplyDischarge = ~convEn;
  assign vccEn           = contactEn[0];
  assign ioEn            = contactEn[1];
  assign clkEn           = contactEn[2];
  assign auxEn           = contactEn[3];
  assign rstEn           = contactEn[4];
  assign ioHiZ           = ~csN | ~ioEn;
  assign auxHiZ          = ~csN | ~auxEn;
endmodule

// File: rtl/card_contact_seq_chk.sv
module card_contact_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic csN,
  input logic pwrReq,
  input logic supplyGood,
  input logic batLow,
  input logic cardOut,
  input logic overCur,
  input logic convEn,
  input logic supplyDischarge,
  input logic vccEn,
  input logic ioEn,
  input logic clkEn,
  input logic auxEn,
  input logic rstEn,
  input logic ioHiZ,
  input logic auxHiZ,
  input logic ready
);
  logic [2:0] onCount;
  assign onCount = 3'($countones({rstEn, auxEn, clkEn, ioEn, vccEn}));

  AST_THERMO_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (rstEn -> auxEn) && (auxEn -> clkEn) && (clkEn -> ioEn) && (ioEn -> vccEn)); // R4

  AST_READY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> rstEn); // R4

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (onCount <= $past(onCount) + 3'd1) && (onCount + 3'd1 >= $past(onCount))); // R6

  AST_CONTACT_NEEDS_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    (vccEn && !batLow) |-> convEn); // R3

  AST_ABORT_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (overCur || cardOut) |=> (onCount <= $past(onCount))); // R7

  AST_BAT_BLOCKS_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    batLow |-> !convEn); // R9

  AST_DISCHARGE_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
    supplyDischarge != convEn); // R10

  AST_HIZ_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !csN |-> (ioHiZ && auxHiZ)); // R11
endmodule

bind card_contact_seq card_contact_seq_chk u_chk (.*);

// File: tb/card_contact_seq_test.sv
module card_contact_seq_test;
  localparam int GAP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csN = 1'b0, pwrReq = 1'b0, supplyGood = 1'b0;
  logic batLow = 1'b0, cardOut = 1'b0, overCur = 1'b0;
  logic convEn, supplyDischarge, vccEn, ioEn, clkEn, auxEn, rstEn, ioHiZ, auxHiZ, ready;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  card_contact_seq #(.STEP_GAP(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .csN(csN), .pwrReq(pwrReq), .supplyGood(supplyGood),
    .batLow(batLow), .cardOut(cardOut), .overCur(overCur), .convEn(convEn),
    .supplyDischarge(supplyDischarge), .vccEn(vccEn), .ioEn(ioEn), .clkEn(clkEn),
    .auxEn(auxEn), .rstEn(rstEn), .ioHiZ(ioHiZ), .auxHiZ(auxHiZ), .ready(ready)
  );

  function automatic int pat();
    return int'({rstEn, auxEn, clkEn, ioEn, vccEn});
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkLevel(string req, int lvl);
    int expPat = (1 << lvl) - 1;
    check(pat() == expPat, req, "contact pattern", pat(), expPat);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic bringUp();
    pwrReq = 1'b1;
    tick();
    tick();
    supplyGood = 1'b1;
    repeat (5 * GAP + 2) tick();
    check(ready == 1'b1, "R4", "ready after bring-up", ready, 1);
  endtask

  task automatic settle();
    pwrReq = 1'b0; supplyGood = 1'b0; cardOut = 1'b0; batLow = 1'b0; overCur = 1'b0; csN = 1'b0;
    repeat (3 * 5 * GAP) tick();
  endtask

  // Abort at edge index a after the supply handshake, using trigger kind 0..3.
  task automatic session(int a, int kind);
    int lvlAt;
    int lastIdle;
    pwrReq = 1'b1;
    tick();
    check(convEn == 1'b1, "R2", "converter after request", convEn, 1);
    checkLevel("R3", 0);
    tick();
    checkLevel("R3", 0);
    supplyGood = 1'b1;
    for (int t = 0; t < a; t++) begin
      int expLvl = (t / GAP > 5) ? 5 : t / GAP;
      tick();
      checkLevel("R4", expLvl);
      check(ready == (t >= 5 * GAP + 1), "R4", "ready during ramp", ready, int'(t >= 5 * GAP + 1));
    end
    lvlAt = (a == 0) ? 0 : (((a - 1) / GAP > 5) ? 5 : (a - 1) / GAP);
    case (kind)
      0: pwrReq = 1'b0;
      1: cardOut = 1'b1;
      2: overCur = 1'b1;
      default: batLow = 1'b1;
    endcase
    lastIdle = lvlAt * GAP + 1;
    for (int s = 0; s <= lastIdle + 2; s++) begin
      int expLvl = lvlAt - s / GAP;
      bit expOn;
      if (expLvl < 0) expLvl = 0;
      tick();
      if (kind == 2) overCur = 1'b0;
      expOn = (s < lastIdle) && (kind != 3);
      checkLevel((s == 0) ? "R7" : "R6", expLvl);
      check(convEn == expOn, (kind == 3) ? "R9" : "R6", "converter during teardown", convEn, int'(expOn));
      check(ready == 1'b0, "R5", "ready after trigger", ready, 0);
      check(supplyDischarge == !convEn, "R10", "discharge", supplyDischarge, int'(!convEn));
    end
    cardOut = 1'b0; batLow = 1'b0; supplyGood = 1'b0;
    repeat (2) begin
      tick();
      check(convEn == 1'b0, "R8", "no restart without new edge", convEn, 0);
      checkLevel("R1", 0);
    end
    pwrReq = 1'b0;
    tick();
  endtask

  initial begin
    #(5.0 * 150000);
    check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(convEn == 1'b0, "R1", "convEn in reset", convEn, 0);
    rst_n = 1'b1;
    tick();
    checkLevel("R1", 0);
    check(convEn == 1'b0, "R1", "convEn idle", convEn, 0);
    check(ready == 1'b0, "R1", "ready idle", ready, 0);
    check(supplyDischarge == 1'b1, "R10", "discharge idle", supplyDischarge, 1);

    // R2: disqualified rising edges
    csN = 1'b1; pwrReq = 1'b1; tick(); tick();
    check(convEn == 1'b0, "R2", "edge while deselected", convEn, 0);
    csN = 1'b0; tick();
    check(convEn == 1'b0, "R2", "held request after select", convEn, 0);
    settle();
    batLow = 1'b1; pwrReq = 1'b1; tick(); batLow = 1'b0; tick();
    check(convEn == 1'b0, "R2", "edge with battery low", convEn, 0);
    settle();
    cardOut = 1'b1; pwrReq = 1'b1; tick(); tick();
    check(convEn == 1'b0, "R2", "edge with card absent", convEn, 0);
    settle();

    // R3: wait for supply indefinitely
    pwrReq = 1'b1; tick();
    repeat (4 * GAP) tick();
    checkLevel("R3", 0);
    check(convEn == 1'b1, "R3", "converter waiting", convEn, 1);
    settle();

    // R11 and R5: high impedance and ignored fall while deselected
    bringUp();
    check(ioHiZ == 1'b1 && auxHiZ == 1'b1, "R11", "hiZ while selected", int'({ioHiZ, auxHiZ}), 3);
    csN = 1'b1; tick();
    check(ioHiZ == 1'b0 && auxHiZ == 1'b0, "R11", "driven while deselected", int'({ioHiZ, auxHiZ}), 0);
    pwrReq = 1'b0;
    repeat (2 * GAP) tick();
    check(ready == 1'b1, "R5", "fall while deselected ignored", ready, 1);
    checkLevel("R5", 5);
    csN = 1'b0; tick();
    check(ready == 1'b1, "R5", "no edge after reselect", ready, 1);
    pwrReq = 1'b1; tick();
    check(ready == 1'b1, "R2", "edge while active ignored", ready, 1);
    pwrReq = 1'b0; tick();
    check(ready == 1'b0, "R5", "fall while selected", ready, 0);
    settle();
    csN = 1'b1; tick();
    check(ioHiZ == 1'b1 && auxHiZ == 1'b1, "R11", "hiZ with contacts off", int'({ioHiZ, auxHiZ}), 3);
    csN = 1'b0;

    // R8: request during teardown is ignored
    bringUp();
    overCur = 1'b1; tick(); overCur = 1'b0;
    pwrReq = 1'b0; tick(); pwrReq = 1'b1;
    repeat (6 * GAP + 3) tick();
    check(convEn == 1'b0, "R8", "edge during teardown", convEn, 0);
    checkLevel("R8", 0);
    settle();

    // Sweep of abort points and trigger kinds
    for (int kind = 0; kind < 4; kind++) begin
      for (int a = 0; a <= 5 * GAP + 3; a++) begin
        session(a, kind);
      end
    end

    finishRun();
  end
endmodule